// File: doc/BRIEF.md
# Busy-Indicator SAR ADC Read Controller

This block is the host side of a link to a 16-bit successive-approximation converter. The converter is wired in a four-wire chip-select arrangement that reports when it is busy. One request on `start_i` runs a full frame. The controller raises the select line and then the convert line, which starts a conversion in chip-select mode. It then drops the select line so that the converter can signal completion. Until that signal, the converter's data output floats and a pull-up holds it high.

When the conversion is done, the converter drives the data line low. The controller synchronises this falling edge and treats it as a ready interrupt. It then runs an even-divided serial clock and collects sixteen bits, most significant first, sampling on falling edges. It closes the frame by raising the select line, and it presents the word with a one-cycle strobe. The convert line then drops for a fixed acquisition interval before a new request is taken. A conversion whose ready edge never arrives is cut off by a timeout, which pulses an error flag.

Top module: `sar_busy_reader`

## Requirements
- R1: A start request accepted in idle raises `sel_o` for `SETUP_CYC` cycles with `cnv_o` low. `cnv_o` then rises while `sel_o` is still high.
- R2: `sel_o` stays high for `SEL_HOLD` cycles after `cnv_o` rises. It then stays low through the wait and the whole readback.
- R3: Once raised, `cnv_o` stays high continuously through the conversion, the wait, the readback and the frame-end interval. It is low during acquisition and idle.
- R4: `sdo_i` goes through a two-flop synchronizer. The first clock edge that samples `sdo_i` low after it was seen high marks the ready edge. Serial clocking begins two cycles after that edge.
- R5: `sck_o` has a period of `SCK_DIV` clock cycles. Each period is low for the first half and high for the second. There are exactly 17 falling edges per frame, and `sck_o` is low outside the readback.
- R6: The bit present on `sdo_i` before falling edges 2 to 17 is captured as bits 15 down to 0 of `data_o`, in that order.
- R7: `valid_o` is a one-cycle pulse in the cycle after the 17th falling edge. `busy_o` is high from the cycle after the start request is accepted, and it is low in the `valid_o` cycle.
- R8: After the 17th falling edge, `sel_o` is high with `cnv_o` high for `SCK_DIV/2` cycles. Both are then low for `ACQ_CYC` cycles before idle.
- R9: If no ready edge is seen within `TMO_CYC` cycles of `sel_o` falling, `timeout_o` pulses for one cycle. In that same cycle, `cnv_o` and `busy_o` are low. No `valid_o` pulse follows, and acquisition of `ACQ_CYC` cycles follows.
- R10: `start_i` has no effect outside idle, including during acquisition.
- R11: While `rst_ni` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, taken only in idle |
| sdo_i | input | 1 | Converter data output, pulled high when released |
| cnv_o | output | 1 | Convert line to the converter |
| sel_o | output | 1 | Select / data-in line to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| data_o | output | DATA_W | Last assembled sample |
| valid_o | output | 1 | One-cycle strobe marking a new `data_o` |
| busy_o | output | 1 | Frame in progress |
| timeout_o | output | 1 | One-cycle pulse on a conversion timeout |

## Verification
A wrong state or counter value shows up at the ports at once, because `sel_o`, `cnv_o` and `busy_o` decode the state register directly. The cycle-by-cycle comparison therefore catches a misstep in the cycle in which it happens. A divider or edge-counter fault shows as a shifted `sck_o` level within half a serial period, or as an extra or missing falling edge before the frame end. A capture fault only becomes visible in the `valid_o` cycle, as a wrong `data_o`. The bench therefore sends all-zero, all-one, single-end-bit and mixed words.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CONV,
    ST_WAIT,
    ST_SHIFT,
    ST_END,
    ST_ACQ
  } rd_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sar_rd_sync.sv
module sar_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic fall_o
);

  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      prev_q <= 1'b0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign q_o    = pipe_q[STAGES-1];
  // high-to-low only; a low-to-high release never counts
  assign fall_o = prev_q & ~pipe_q[STAGES-1];

endmodule

// File: rtl/sar_rd_sck.sv
module sar_rd_sck #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic fall_o
);

  localparam int HALF = DIV / 2;
  localparam int DW   = $clog2(DIV);

  logic [DW-1:0] dc_q;
  logic          sck_q;
  logic          at_mid;
  logic          at_last;

  assign at_mid  = (dc_q == DW'(HALF - 1));
  assign at_last = (dc_q == DW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_q  <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      dc_q  <= '0;
      sck_q <= 1'b0;
    end else begin
      dc_q <= at_last ? '0 : dc_q + 1'b1;
      if (at_mid)       sck_q <= 1'b1;
      else if (at_last) sck_q <= 1'b0;
    end
  end

  assign sck_o  = sck_q;
  assign fall_o = run_i & at_last;

endmodule

// File: rtl/sar_rd_shift.sv
module sar_rd_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[W-2:0], bit_i};
  end

  assign word_o = sr_q;

endmodule

// File: rtl/sar_busy_reader.sv
module sar_busy_reader
  import sar_rd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SCK_DIV     = 8,
  parameter int SETUP_CYC   = 2,
  parameter int SEL_HOLD    = 4,
  parameter int TMO_CYC     = 400,
  parameter int ACQ_CYC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sel_o,
  output logic              sck_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              timeout_o
);

  localparam int HALF = SCK_DIV / 2;
  localparam int CMAX = max_of(max_of(SETUP_CYC, SEL_HOLD),
                               max_of(max_of(TMO_CYC, ACQ_CYC), HALF));
  localparam int CW   = $clog2(CMAX + 1);
  localparam int FW   = $clog2(DATA_W + 1);

  rd_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic [FW-1:0] fc_q;
  logic valid_q, tmo_q;
  logic sdo_s, eoc_fall, sck_fall, sck_run, cap;

  sar_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sdo_i),
    .q_o   (sdo_s),
    .fall_o(eoc_fall)
  );

  assign sck_run = (st_q == ST_SHIFT);

  sar_rd_sck #(.DIV(SCK_DIV)) u_sck (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (sck_run),
    .sck_o (sck_o),
    .fall_o(sck_fall)
  );

  // first falling edge launches the MSB; capture on edges 2..DATA_W+1
  assign cap = sck_run & sck_fall & (fc_q != '0);

  sar_rd_shift #(.W(DATA_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cap),
    .bit_i (sdo_s),
    .word_o(data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      fc_q    <= '0;
      valid_q <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      tmo_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          fc_q <= '0;
          if (start_i) begin
            st_q  <= ST_SETUP;
            cnt_q <= CW'(SETUP_CYC - 1);
          end
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            st_q  <= ST_CONV;
            cnt_q <= CW'(SEL_HOLD - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_CONV: begin
          if (cnt_q == '0) begin
            st_q  <= ST_WAIT;
            cnt_q <= CW'(TMO_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_WAIT: begin
          if (eoc_fall) begin
            st_q <= ST_SHIFT;
          end else if (cnt_q == '0) begin
            st_q  <= ST_ACQ;
            cnt_q <= CW'(ACQ_CYC - 1);
            tmo_q <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_SHIFT: begin
          if (sck_fall) begin
            if (fc_q == FW'(DATA_W)) begin
              st_q    <= ST_END;
              cnt_q   <= CW'(HALF - 1);
              valid_q <= 1'b1;
            end else fc_q <= fc_q + 1'b1;
          end
        end
        ST_END: begin
          if (cnt_q == '0) begin
            st_q  <= ST_ACQ;
            cnt_q <= CW'(ACQ_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_ACQ: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sel_o  = (st_q == ST_SETUP) || (st_q == ST_CONV) || (st_q == ST_END);
    cnv_o  = (st_q == ST_CONV) || (st_q == ST_WAIT) ||
             (st_q == ST_SHIFT) || (st_q == ST_END);
    busy_o = (st_q == ST_SETUP) || (st_q == ST_CONV) ||
             (st_q == ST_WAIT) || (st_q == ST_SHIFT);
  end

  assign valid_o   = valid_q;
  assign timeout_o = tmo_q;

  assert_sel_at_cnv_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> sel_o);

  assert_sck_sel_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> (!sel_o && cnv_o));

  assert_sck_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnv_o |-> !sck_o);

  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_busy_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (valid_o || timeout_o));

  assert_tmo_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!cnv_o && !busy_o && !valid_o));

endmodule

// File: tb/sim_sar_busy_reader.sv
module sim_sar_busy_reader;

  localparam int W    = 16;
  localparam int DIV  = 6;
  localparam int HALF = DIV / 2;
  localparam int S    = 2;
  localparam int H    = 4;
  localparam int TMO  = 200;
  localparam int ACQ  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sdo = 1'b0;
  logic cnv_o, sel_o, sck_o, valid_o, busy_o, timeout_o;
  logic [W-1:0] data_o;

  always #2 clk = ~clk;

  sar_busy_reader #(
    .DATA_W(W), .SCK_DIV(DIV), .SETUP_CYC(S), .SEL_HOLD(H),
    .TMO_CYC(TMO), .ACQ_CYC(ACQ), .SYNC_STAGES(2)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sdo_i(sdo),
    .cnv_o(cnv_o), .sel_o(sel_o), .sck_o(sck_o), .data_o(data_o),
    .valid_o(valid_o), .busy_o(busy_o), .timeout_o(timeout_o)
  );

  typedef struct packed {
    logic sel, cnv, sck, busy, valid, tmo;
    logic [W-1:0] data;
  } vec_t;

  vec_t  exp_q[$];
  string tag_q[$];
  int checks = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic push(input logic sel, input logic cnv, input logic sck, input logic busy,
                      input logic valid, input logic tmo, input logic [W-1:0] d,
                      input string tag);
    vec_t v;
    v.sel = sel; v.cnv = cnv; v.sck = sck; v.busy = busy;
    v.valid = valid; v.tmo = tmo; v.data = d;
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // converter model, evaluated away from the active edge
  logic [W-1:0] cv_word = '0;
  int cv_t = 0;
  int cv_cnt = 0;
  int cv_bit = 0;
  bit cv_busy = 1'b0, cv_arm = 1'b0, cv_read = 1'b0;
  logic cnv_p = 1'b0, sel_p = 1'b0, sck_p = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cnv_o && !cnv_p) begin
        chk(sel_o === 1'b1, "R1", "sel at convert rise", int'(sel_o), 1);
        cv_busy = 1'b1; cv_cnt = cv_t; cv_arm = sel_o; cv_read = 1'b0; cv_bit = 0;
        sdo <= 1'b1;
      end else if (!cnv_o) begin
        cv_busy = 1'b0; cv_read = 1'b0;
        if (!sel_o) sdo <= 1'b0;
      end else begin
        if (cv_busy) begin
          cv_cnt--;
          if (cv_cnt == 0) begin
            cv_busy = 1'b0;
            chk(sel_o === 1'b0, "R2", "sel low at conversion end", int'(sel_o), 0);
            if (cv_arm && !sel_o) begin sdo <= 1'b0; cv_read = 1'b1; end
          end
        end
        if (cv_read && !sck_o && sck_p) begin
          if (cv_bit < W) begin sdo <= cv_word[W-1-cv_bit]; cv_bit++; end
          else begin sdo <= 1'b1; cv_read = 1'b0; end
        end
        if (cv_read && sel_o && !sel_p) begin sdo <= 1'b1; cv_read = 1'b0; end
      end
    end
    cnv_p = cnv_o; sel_p = sel_o; sck_p = sck_o;
  end

  // cycle-by-cycle comparison against the expected queue
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      vec_t  e;
      string t;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = '0;
        t = "R10";
      end
      chk(sel_o === e.sel, t, "sel_o", int'(sel_o), int'(e.sel));
      chk(cnv_o === e.cnv, "R3", "cnv_o", int'(cnv_o), int'(e.cnv));
      chk(sck_o === e.sck, t, "sck_o", int'(sck_o), int'(e.sck));
      chk(busy_o === e.busy, "R7", "busy_o", int'(busy_o), int'(e.busy));
      chk(valid_o === e.valid, "R7", "valid_o", int'(valid_o), int'(e.valid));
      chk(timeout_o === e.tmo, "R9", "timeout_o", int'(timeout_o), int'(e.tmo));
      if (e.valid) chk(data_o === e.data, "R6", "data_o", int'(data_o), int'(e.data));
    end
  end

  task automatic push_frame(input logic [W-1:0] w, input int ct, input bit to);
    for (int i = 0; i < S; i++) push(1, 0, 0, 1, 0, 0, '0, "R1");
    for (int i = 0; i < H; i++) push(1, 1, 0, 1, 0, 0, '0, "R2");
    if (to) begin
      for (int i = 0; i < TMO; i++) push(0, 1, 0, 1, 0, 0, '0, "R9");
      for (int i = 0; i < ACQ; i++) push(0, 0, 0, 0, 0, i == 0, '0, "R9");
    end else begin
      for (int i = 0; i < ct + 3 - H; i++) push(0, 1, 0, 1, 0, 0, '0, "R4");
      for (int j = 0; j < 17 * DIV; j++) push(0, 1, (j % DIV) >= HALF, 1, 0, 0, '0, "R5");
      for (int i = 0; i < HALF; i++) push(1, 1, 0, 0, i == 0, 0, w, "R8");
      for (int i = 0; i < ACQ; i++) push(0, 0, 0, 0, 0, 0, '0, "R8");
    end
  endtask

  // poke: 0 none, 1 extra start while waiting, 2 extra start during acquisition (R10)
  task automatic run_frame(input logic [W-1:0] w, input int ct, input bit to, input int poke);
    int len;
    int at;
    @(negedge clk); #1;
    cv_word = w;
    cv_t = to ? 1000 : ct;
    start = 1'b1;
    push_frame(w, ct, to);
    len = exp_q.size();
    @(negedge clk); #1;
    start = 1'b0;
    if (poke != 0) begin
      at = (poke == 1) ? (S + H + 2) : (len - 2);
      repeat (at) @(negedge clk);
      #1 start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
    end
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(cnv_o === 1'b0, "R11", "cnv_o in reset", int'(cnv_o), 0);
    chk(sel_o === 1'b0, "R11", "sel_o in reset", int'(sel_o), 0);
    chk(sck_o === 1'b0, "R11", "sck_o in reset", int'(sck_o), 0);
    chk(busy_o === 1'b0, "R11", "busy_o in reset", int'(busy_o), 0);
    chk(valid_o === 1'b0, "R11", "valid_o in reset", int'(valid_o), 0);
    chk(timeout_o === 1'b0, "R11", "timeout_o in reset", int'(timeout_o), 0);
    chk(data_o === '0, "R11", "data_o in reset", int'(data_o), 0);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_frame(16'hA5C3, 20, 0, 0);
    run_frame(16'h0000, H, 0, 0);            // shortest legal conversion
    run_frame(16'hFFFF, H + TMO - 3, 0, 0);  // longest conversion before timeout
    run_frame(16'h8001, 37, 0, 1);           // R10 start during wait
    run_frame(16'h5A3C, 10, 0, 2);           // R10 start during acquisition
    run_frame(16'h0000, 0, 1, 0);            // R9 timeout
    run_frame(16'h1234, 9, 0, 0);            // recovery after timeout
    for (int k = 0; k < 6; k++)
      run_frame(W'((k + 3) * 16'h1D87) ^ W'(k << 11), H + k * 13, 0, 0);

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, frame sequence hung");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule